// File: doc/BRIEF.md
# Equalizer Sweep Controller with Error-Count Selection

This block runs a search over transmitter equalizer settings and keeps the one with the fewest bit errors. After a start pulse it steps through a fixed order of candidates: the initial setting, the preset setting, a run of main-tap steps and then a run of pre/post-tap steps. For each candidate it presents a tap request. It then counts error pulses over a window of frame-tick strobes and compares the total against the best result so far, using a coded hysteresis margin.

When the search ends, the block raises a done flag. It reports the winning setting and its error count, a failure flag and an excessive-error flag. A quick mode limits the search to the two fixed settings. With the multi-minimum option cleared, the search stops at the first measurement that is worse than the one before it. A wait limit aborts a search that runs too long. No streaming data passes through the block, so every pin is a plain control or status signal with no back-pressure.

Top module: `eqs_sweep_ctrl`

## Requirements
- R1: `tap_req` is {phase[1:0], step[3:0]}. Candidates come in the order 0x00 (initial), 0x10 (preset), 0x20|k for k = 1..main steps, then 0x30|k for k = 1..pre/post steps. A step count of zero skips its phase.
- R2: The window is `cfg_win_frames` frames when `cfg_win_kframes` is zero, with zero treated as one frame. Otherwise it is kframes*1000 + mframes*1000000 frames. Each candidate takes W frame ticks plus one evaluation cycle. With a tick every cycle, `done` rises N*(W+1) clock edges after the edge that samples `start`, where N is the number of candidates evaluated.
- R3: The error count is cleared at the start of each window, counts one per cycle in which `err_inc` is high during measurement, and saturates at 2^ERR_W-1.
- R4: The first measurement always becomes the best. A later one replaces it only when count + margin < best count. The margin decodes `cfg_hyst` as 0..4 for codes 0..4, 8 for code 5 and 16 for codes 6 and 7.
- R5: With `cfg_quick` set, only 0x00 and 0x10 are evaluated.
- R6: With `cfg_multi_min` clear, the search ends after the first measurement whose count exceeds the previous measurement's count.
- R7: With `cfg_strict` set, a nonzero count on the final measurement sets `train_fail` at completion.
- R8: Counted from the edge that samples `start`, the block aborts with `done` and `train_fail` set MAXWAIT_CYC edges later, unless `cfg_wait_dis` is set.
- R9: `excess_err` is set at normal completion when the final best count exceeds ERR_LIMIT.
- R10: `start` is ignored while `busy` is high. An accepted start clears `done`, `train_fail` and `excess_err`, and results hold until the next accepted start.
- R11: After reset, `busy`, `done`, `train_fail`, `excess_err`, `tap_req`, `best_tap` and `best_errs` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled when idle |
| frame_tick | input | 1 | One training frame elapsed |
| err_inc | input | 1 | One bit error seen this cycle |
| cfg_quick | input | 1 | Quick mode: fixed settings only |
| cfg_multi_min | input | 1 | Search past the first local minimum |
| cfg_strict | input | 1 | Fail on a nonzero final count |
| cfg_wait_dis | input | 1 | Disable the wait-limit abort |
| cfg_hyst | input | 3 | Hysteresis margin code |
| cfg_main_steps | input | 4 | Number of main-tap steps |
| cfg_prpo_steps | input | 4 | Number of pre/post-tap steps |
| cfg_win_frames | input | 10 | Window in frames |
| cfg_win_kframes | input | 10 | Window in thousands of frames |
| cfg_win_mframes | input | 10 | Window extension in millions of frames |
| busy | output | 1 | Search in progress |
| tap_req | output | 6 | Current candidate setting |
| done | output | 1 | Search ended |
| best_tap | output | 6 | Best setting found |
| best_errs | output | ERR_W | Error count of the best setting |
| train_fail | output | 1 | Training failed (strict or wait limit) |
| excess_err | output | 1 | Best count above ERR_LIMIT |

## Verification
`busy` and the first request 0x00 are visible one edge after start is sampled. `tap_req` moves on every W+1 edges, on the evaluation edge. `done` and all result flags change together on the final evaluation edge, or on the abort edge at MAXWAIT_CYC. The bench drives inputs 1 ns after a falling edge and samples 2 ns after a rising edge. For each run it checks that `done` is still low one edge before the due edge and high on it, so a result that comes one cycle early or late is caught. The error stimulus is generated from the presented `tap_req`, so each candidate's count is known exactly.

// File: rtl/eqs_pkg.sv
package eqs_pkg;
  typedef enum logic [1:0] {
    PH_INIT   = 2'd0,
    PH_PRESET = 2'd1,
    PH_MAIN   = 2'd2,
    PH_PRPO   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEAS = 2'd1,
    ST_EVAL = 2'd2
  } state_e;

  function automatic logic [4:0] hyst_margin(input logic [2:0] code);
    case (code)
      3'd5:    return 5'd8;
      3'd6,
      3'd7:    return 5'd16;
      default: return {2'b00, code};
    endcase
  endfunction
endpackage

// File: rtl/eqs_window.sv
module eqs_window #(
  parameter int FR_W  = 10,
  parameter int WIN_W = 32
) (
  input  logic [FR_W-1:0]  frames,
  input  logic [FR_W-1:0]  kframes,
  input  logic [FR_W-1:0]  mframes,
  output logic [WIN_W-1:0] win_len
);
  localparam logic [WIN_W-1:0] KILO = WIN_W'(1000);
  localparam logic [WIN_W-1:0] MEGA = WIN_W'(1000000);

  always_comb begin
    if (kframes == '0) begin
      win_len = (frames == '0) ? WIN_W'(1) : WIN_W'(frames);
    end else begin
      win_len = WIN_W'(kframes) * KILO + WIN_W'(mframes) * MEGA;
    end
  end
endmodule

// File: rtl/eqs_meter.sv
module eqs_meter #(
  parameter int WIN_W = 32,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             frame_tick,
  input  logic             err_inc,
  input  logic [WIN_W-1:0] win_len,
  output logic [ERR_W-1:0] err_cnt,
  output logic             win_end
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [WIN_W-1:0] frames_q;

  assign win_end = en && frame_tick && (frames_q == win_len - WIN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      frames_q <= '0;
      err_cnt  <= '0;
    end else if (en) begin
      if (frame_tick) frames_q <= frames_q + WIN_W'(1);
      if (err_inc && err_cnt != ERR_MAX) err_cnt <= err_cnt + ERR_W'(1);
    end
  end

  assert_err_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> err_cnt >= $past(err_cnt));
  assert_err_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && err_cnt == ERR_MAX) |=> err_cnt == ERR_MAX);
endmodule

// File: rtl/eqs_best.sv
module eqs_best #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval,
  input  logic             first,
  input  logic [5:0]       cand_tap,
  input  logic [ERR_W-1:0] cand_errs,
  input  logic [4:0]       margin,
  output logic             take,
  output logic [5:0]       best_tap,
  output logic [ERR_W-1:0] best_errs
);
  localparam int CW = ERR_W + 6;

  logic [CW-1:0] lhs;
  logic [CW-1:0] rhs;

  assign lhs  = CW'(cand_errs) + CW'(margin);
  assign rhs  = CW'(best_errs);
  assign take = first || (lhs < rhs);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_tap  <= '0;
      best_errs <= '0;
    end else if (eval && take) begin
      best_tap  <= cand_tap;
      best_errs <= cand_errs;
    end
  end

  assert_best_no_worse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !first) |=> best_errs <= $past(best_errs));
endmodule

// File: rtl/eqs_sweep_ctrl.sv
module eqs_sweep_ctrl
  import eqs_pkg::*;
#(
  parameter int ERR_W       = 8,
  parameter int WIN_W       = 32,
  parameter int ERR_LIMIT   = 16,
  parameter int MAXWAIT_CYC = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             frame_tick,
  input  logic             err_inc,
  input  logic             cfg_quick,
  input  logic             cfg_multi_min,
  input  logic             cfg_strict,
  input  logic             cfg_wait_dis,
  input  logic [2:0]       cfg_hyst,
  input  logic [3:0]       cfg_main_steps,
  input  logic [3:0]       cfg_prpo_steps,
  input  logic [9:0]       cfg_win_frames,
  input  logic [9:0]       cfg_win_kframes,
  input  logic [9:0]       cfg_win_mframes,
  output logic             busy,
  output logic [5:0]       tap_req,
  output logic             done,
  output logic [5:0]       best_tap,
  output logic [ERR_W-1:0] best_errs,
  output logic             train_fail,
  output logic             excess_err
);
  localparam int MW_W = $clog2(MAXWAIT_CYC + 1);
  localparam logic [MW_W-1:0]  WAIT_LAST = MW_W'(MAXWAIT_CYC - 1);
  localparam logic [ERR_W-1:0] LIMIT_V   = ERR_W'(ERR_LIMIT);

  state_e           state_q;
  phase_e           phase_q, phase_n;
  logic [3:0]       step_q, step_n;
  logic             first_q, last_c, stop_early, finish, accept, abort;
  logic             quick_q, multi_q, strict_q, wait_dis_q;
  logic [4:0]       margin_q;
  logic [3:0]       main_q, prpo_q;
  logic [WIN_W-1:0] win_c, win_q;
  logic [MW_W-1:0]  wcnt_q;
  logic [ERR_W-1:0] meas_errs, prev_errs, fin_best;
  logic             win_end, take;

  assign busy    = (state_q != ST_IDLE);
  assign tap_req = {phase_q, step_q};
  assign accept  = start && !busy;
  assign abort   = busy && !wait_dis_q && (wcnt_q == WAIT_LAST);

  eqs_window #(.FR_W(10), .WIN_W(WIN_W)) u_window (
    .frames (cfg_win_frames),
    .kframes(cfg_win_kframes),
    .mframes(cfg_win_mframes),
    .win_len(win_c)
  );

  eqs_meter #(.WIN_W(WIN_W), .ERR_W(ERR_W)) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (accept || state_q == ST_EVAL),
    .en        (state_q == ST_MEAS),
    .frame_tick(frame_tick),
    .err_inc   (err_inc),
    .win_len   (win_q),
    .err_cnt   (meas_errs),
    .win_end   (win_end)
  );

  eqs_best #(.ERR_W(ERR_W)) u_best (
    .clk      (clk),
    .rst_n    (rst_n),
    .eval     (state_q == ST_EVAL),
    .first    (first_q),
    .cand_tap (tap_req),
    .cand_errs(meas_errs),
    .margin   (margin_q),
    .take     (take),
    .best_tap (best_tap),
    .best_errs(best_errs)
  );

  // Next candidate in the sweep order
  always_comb begin
    phase_n = phase_q;
    step_n  = step_q;
    last_c  = 1'b0;
    case (phase_q)
      PH_INIT: begin
        phase_n = PH_PRESET;
        step_n  = 4'd0;
      end
      PH_PRESET: begin
        if (quick_q || (main_q == 4'd0 && prpo_q == 4'd0)) begin
          last_c = 1'b1;
        end else if (main_q != 4'd0) begin
          phase_n = PH_MAIN;
          step_n  = 4'd1;
        end else begin
          phase_n = PH_PRPO;
          step_n  = 4'd1;
        end
      end
      PH_MAIN: begin
        if (step_q != main_q) begin
          step_n = step_q + 4'd1;
        end else if (prpo_q != 4'd0) begin
          phase_n = PH_PRPO;
          step_n  = 4'd1;
        end else begin
          last_c = 1'b1;
        end
      end
      default: begin
        if (step_q != prpo_q) step_n = step_q + 4'd1;
        else                  last_c = 1'b1;
      end
    endcase
  end

  assign stop_early = !multi_q && !first_q && (meas_errs > prev_errs);
  assign finish     = last_c || stop_early;
  assign fin_best   = take ? meas_errs : best_errs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      phase_q    <= PH_INIT;
      step_q     <= '0;
      first_q    <= 1'b0;
      prev_errs  <= '0;
      wcnt_q     <= '0;
      done       <= 1'b0;
      train_fail <= 1'b0;
      excess_err <= 1'b0;
      quick_q    <= 1'b0;
      multi_q    <= 1'b0;
      strict_q   <= 1'b0;
      wait_dis_q <= 1'b0;
      margin_q   <= '0;
      main_q     <= '0;
      prpo_q     <= '0;
      win_q      <= WIN_W'(1);
    end else if (accept) begin
      state_q    <= ST_MEAS;
      phase_q    <= PH_INIT;
      step_q     <= '0;
      first_q    <= 1'b1;
      wcnt_q     <= '0;
      done       <= 1'b0;
      train_fail <= 1'b0;
      excess_err <= 1'b0;
      quick_q    <= cfg_quick;
      multi_q    <= cfg_multi_min;
      strict_q   <= cfg_strict;
      wait_dis_q <= cfg_wait_dis;
      margin_q   <= hyst_margin(cfg_hyst);
      main_q     <= cfg_main_steps;
      prpo_q     <= cfg_prpo_steps;
      win_q      <= win_c;
    end else if (busy) begin
      if (!wait_dis_q) wcnt_q <= wcnt_q + MW_W'(1);
      if (abort) begin
        state_q    <= ST_IDLE;
        done       <= 1'b1;
        train_fail <= 1'b1;
      end else if (state_q == ST_MEAS) begin
        if (win_end) state_q <= ST_EVAL;
      end else begin
        prev_errs <= meas_errs;
        first_q   <= 1'b0;
        if (finish) begin
          state_q    <= ST_IDLE;
          done       <= 1'b1;
          train_fail <= strict_q && (meas_errs != '0);
          excess_err <= fin_best > LIMIT_V;
        end else begin
          state_q <= ST_MEAS;
          phase_q <= phase_n;
          step_q  <= step_n;
        end
      end
    end
  end

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
  assert_fail_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    train_fail |-> done);
  assert_tap_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MEAS && !win_end && !abort) |=> $stable(tap_req));
  assert_quick_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && quick_q) |-> !tap_req[5]);
  assert_wait_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wait_dis_q) |-> wcnt_q <= WAIT_LAST);
  assert_win_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> win_q != '0);
endmodule

// File: tb/eqs_sweep_ctrl_tb_top.sv
`timescale 1ns/1ps
module eqs_sweep_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic frame_tick = 1'b0;
  logic err_inc = 1'b0;
  logic cfg_quick, cfg_multi_min, cfg_strict, cfg_wait_dis;
  logic [2:0] cfg_hyst;
  logic [3:0] cfg_main_steps, cfg_prpo_steps;
  logic [9:0] cfg_win_frames, cfg_win_kframes, cfg_win_mframes;
  logic       busy, done, train_fail, excess_err;
  logic [5:0] tap_req, best_tap;
  logic [7:0] best_errs;

  int checks = 0;
  int errors = 0;
  int tgt [64];
  int age = 0;
  logic [5:0] last_tap = '0;
  logic       last_busy = 1'b0;

  always #5 clk = ~clk;

  eqs_sweep_ctrl #(.ERR_W(8), .WIN_W(32), .ERR_LIMIT(16), .MAXWAIT_CYC(300)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_tick(frame_tick), .err_inc(err_inc),
    .cfg_quick(cfg_quick), .cfg_multi_min(cfg_multi_min), .cfg_strict(cfg_strict),
    .cfg_wait_dis(cfg_wait_dis), .cfg_hyst(cfg_hyst), .cfg_main_steps(cfg_main_steps),
    .cfg_prpo_steps(cfg_prpo_steps), .cfg_win_frames(cfg_win_frames),
    .cfg_win_kframes(cfg_win_kframes), .cfg_win_mframes(cfg_win_mframes),
    .busy(busy), .tap_req(tap_req), .done(done), .best_tap(best_tap),
    .best_errs(best_errs), .train_fail(train_fail), .excess_err(excess_err)
  );

  // Channel model: each candidate yields min(tgt, window) error pulses
  always @(negedge clk) begin
    if (tap_req != last_tap || (busy && !last_busy)) age = 0;
    else age = age + 1;
    last_tap  = tap_req;
    last_busy = busy;
    err_inc    = (age < tgt[tap_req]);
    frame_tick = 1'b1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_tgts(input int a00, input int a10, input int a21, input int a22, input int a31);
    for (int i = 0; i < 64; i++) tgt[i] = 0;
    tgt[6'h00] = a00; tgt[6'h10] = a10; tgt[6'h21] = a21; tgt[6'h22] = a22; tgt[6'h31] = a31;
  endtask

  task automatic defaults();
    cfg_quick = 0; cfg_multi_min = 1; cfg_strict = 0; cfg_wait_dis = 0;
    cfg_hyst = 3'd0; cfg_main_steps = 4'd2; cfg_prpo_steps = 4'd1;
    cfg_win_frames = 10'd8; cfg_win_kframes = 10'd0; cfg_win_mframes = 10'd0;
  endtask

  task automatic pulse_start();
    @(negedge clk); #1 start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
  endtask

  task automatic run_case(input string req, input int cyc, input bit chk_best,
                          input int e_tap, input int e_errs, input int e_fail, input int e_exc);
    pulse_start();
    check({req, " busy after start (R10)"}, busy, 1);
    check({req, " first request 0x00 (R1)"}, tap_req, 0);
    repeat (cyc - 2) @(posedge clk);
    @(posedge clk); #2;
    check({req, " done not early (R2)"}, done, 0);
    @(posedge clk); #2;
    check({req, " done on time (R2)"}, done, 1);
    check({req, " idle at end (R10)"}, busy, 0);
    if (chk_best) begin
      check({req, " best tap"}, best_tap, e_tap);
      check({req, " best count"}, best_errs, e_errs);
    end
    check({req, " fail flag"}, train_fail, e_fail);
    check({req, " excess flag (R9)"}, excess_err, e_exc);
  endtask

  task automatic t_reset();
    check("R11 busy", busy, 0);
    check("R11 done", done, 0);
    check("R11 fail", train_fail, 0);
    check("R11 excess", excess_err, 0);
    check("R11 tap_req", tap_req, 0);
    check("R11 best_tap", best_tap, 0);
    check("R11 best_errs", best_errs, 0);
  endtask

  task automatic t_full_sweep();
    defaults(); set_tgts(5, 6, 3, 4, 2);
    pulse_start();
    check("R1 step0 0x00", tap_req, 6'h00);
    repeat (9) @(posedge clk); #2 check("R1 step1 0x10", tap_req, 6'h10);
    repeat (9) @(posedge clk); #2 check("R1 step2 0x21", tap_req, 6'h21);
    repeat (9) @(posedge clk); #2 check("R1 step3 0x22", tap_req, 6'h22);
    repeat (9) @(posedge clk); #2 check("R1 step4 0x31", tap_req, 6'h31);
    repeat (8) @(posedge clk); #2 check("R2 done not early", done, 0);
    @(posedge clk); #2 check("R2 done at 45", done, 1);
    check("R3 R4 best tap", best_tap, 6'h31);
    check("R3 best count cleared per window", best_errs, 2);
    check("R7 no strict no fail", train_fail, 0);
    check("R9 below limit", excess_err, 0);
  endtask

  task automatic t_hyst2();
    defaults(); cfg_hyst = 3'd2; set_tgts(5, 4, 2, 1, 0);
    run_case("R4 margin2", 45, 1, 6'h21, 2, 0, 0);
  endtask

  task automatic t_hyst8();
    defaults(); cfg_hyst = 3'd5; set_tgts(8, 0, 0, 0, 0);
    run_case("R4 code5 margin8", 45, 1, 6'h00, 8, 0, 0);
  endtask

  task automatic t_quick();
    defaults(); cfg_quick = 1; set_tgts(5, 3, 0, 0, 0);
    run_case("R5 quick", 18, 1, 6'h10, 3, 0, 0);
  endtask

  task automatic t_single_min();
    defaults(); cfg_multi_min = 0; set_tgts(5, 4, 6, 1, 0);
    run_case("R6 first minimum", 27, 1, 6'h10, 4, 0, 0);
  endtask

  task automatic t_strict();
    defaults(); cfg_strict = 1; set_tgts(3, 3, 3, 3, 1);
    run_case("R7 strict", 45, 1, 6'h31, 1, 1, 0);
  endtask

  task automatic t_skip_main();
    defaults(); cfg_main_steps = 4'd0; set_tgts(5, 5, 0, 0, 1);
    run_case("R1 zero main steps", 27, 1, 6'h31, 1, 0, 0);
  endtask

  task automatic t_saturate();
    defaults(); cfg_quick = 1; cfg_wait_dis = 1; cfg_win_kframes = 10'd1;
    set_tgts(400, 300, 0, 0, 0);
    run_case("R3 R8 saturate kilo window", 2002, 1, 6'h00, 255, 0, 1);
  endtask

  task automatic t_maxwait();
    defaults(); cfg_quick = 1; cfg_win_kframes = 10'd1;
    set_tgts(0, 0, 0, 0, 0);
    run_case("R8 wait abort", 300, 0, 0, 0, 1, 0);
  endtask

  task automatic t_ignore_start();
    defaults(); set_tgts(0, 0, 0, 0, 0);
    pulse_start();
    repeat (19) @(posedge clk);
    pulse_start();
    repeat (24) @(posedge clk); #2 check("R10 restart ignored, not early", done, 0);
    @(posedge clk); #2 check("R10 restart ignored, done at 45", done, 1);
    check("R10 best tap", best_tap, 6'h00);
    check("R10 best count", best_errs, 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    defaults(); set_tgts(0, 0, 0, 0, 0);
    repeat (4) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #2;
    t_reset();
    t_full_sweep();
    t_hyst2();
    t_hyst8();
    t_quick();
    t_single_min();
    t_strict();
    t_skip_main();
    t_saturate();
    t_maxwait();
    t_ignore_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule